// File: doc/BRIEF.md
# Two-Wire Bus Bit-Clock Divider with Nearest-Ratio Search

This block turns the peripheral clock into the bit-clock enable that paces a two-wire serial byte controller. A 6-bit divider index selects one of 64 fixed division ratios. The bit-clock enable pulses four times per serial-clock period, so one serial-clock period spans exactly the selected ratio in input clocks. The ratio table is not monotonic. Indices 0 to 31 form one ramp from 30 to 3840. Indices 32 to 63 form a second, finer ramp from 22 to 2048. The two ramps share several values.

A second function converts a wanted division ratio into the best index. Software presents a ratio with a start pulse. The unit walks the table one entry per clock, starting at index 0, and reports the index whose ratio is nearest, together with a one-cycle done pulse. If the request lies outside the usable range, the unit answers at once with an error flag.

Top module: `sdiv_scl_divider`

## Requirements
- R1: Index i selects ratio T(i). For i in 0..31, T is 30,32,36,42,48,52,60,72,80,88,104,128,144,160,192,240,288,320,384,480,576,640,768,960,1152,1280,1536,1920,2304,2560,3072,3840. For i in 32..63, T is 22,24,26,28,32,36,40,44,48,56,64,72,80,96,112,128,160,192,224,256,320,384,448,512,640,768,896,1024,1280,1536,1792,2048.
- R2: Each serial-clock period of T input clocks holds four one-cycle bit ticks. Quarter q (q = 0..3) lasts floor(T/4) clocks, plus one clock when q < (T mod 4). Four consecutive ticks therefore span exactly T clocks.
- R3: When the index input differs from the index in use, the divider restarts at quarter 0 with the new ratio. No tick occurs until L0 clocks after the sampling edge, where L0 is the length of quarter 0 of the new ratio. Two ticks are never adjacent.
- R4: While reset is held, bit_tick_o and srch_done_o are low. After release with index 0 in use, the first tick comes on the 8th rising edge and the fourth tick comes on the 30th.
- R5: A valid search returns the index whose ratio has the smallest absolute difference from the request.
- R6: On equal difference the lower index is kept. Only a strictly smaller difference replaces the current best.
- R7: On an exact match at index k, the search stops there. srch_done_o is seen after k+2 rising edges, counting the edge that samples the start.
- R8: Without an exact match, all 64 entries are examined and srch_done_o is seen after 65 rising edges.
- R9: A request of 22 or less, or above 3840, gives srch_done_o with srch_err_o high and index 0 after one rising edge. A valid search reports srch_err_o low.
- R10: srch_done_o is high for a single cycle. A start pulse while a search runs is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_idx_i | input | 6 | Divider index in use |
| bit_tick_o | output | 1 | Bit-clock enable, four pulses per serial-clock period |
| srch_start_i | input | 1 | Starts a nearest-ratio search |
| srch_ratio_i | input | 12 | Wanted division ratio |
| srch_done_o | output | 1 | One-cycle search completion pulse |
| srch_idx_o | output | 6 | Index found by the last search |
| srch_err_o | output | 1 | Last request was outside the valid range |

## Verification
Tick timing is measured in rising edges from the edge that samples a new index. The first tick is due after L0+1 edges and the fourth after T+1 edges; after reset the counts are 8 and 30. The bench counts edges and samples outputs on falling edges, so every comparison targets an exact edge number. Search results are due after 1 edge for a rejected request, after k+2 edges for an exact match at index k, and after 65 edges otherwise. The bench checks that count, then checks one edge later that the done pulse has fallen.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;

   // Division ratio selected by a 6-bit index. Two interleaved ramps;
   // from the 13th entry of each half onward, each block of four
   // entries is the previous block doubled, so the values are computed.
   function automatic logic [11:0] ratio_of(input logic [5:0] i);
      logic [4:0]  j;
      logic [4:0]  k;
      logic [15:0] v;
      j = i[4:0];
      k = 5'd0;
      v = 16'd0;
      if (!i[5]) begin
         if (j < 5'd12) begin
            case (j[3:0])
               4'd0:    v = 16'd30;
               4'd1:    v = 16'd32;
               4'd2:    v = 16'd36;
               4'd3:    v = 16'd42;
               4'd4:    v = 16'd48;
               4'd5:    v = 16'd52;
               4'd6:    v = 16'd60;
               4'd7:    v = 16'd72;
               4'd8:    v = 16'd80;
               4'd9:    v = 16'd88;
               4'd10:   v = 16'd104;
               default: v = 16'd128;
            endcase
         end else begin
            k = j - 5'd12;
            case (k[1:0])
               2'd0:    v = 16'd9;
               2'd1:    v = 16'd10;
               2'd2:    v = 16'd12;
               default: v = 16'd15;
            endcase
            v = v << (4 + k[4:2]);
         end
      end else begin
         if (j < 5'd12) begin
            case (j[3:0])
               4'd0:    v = 16'd22;
               4'd1:    v = 16'd24;
               4'd2:    v = 16'd26;
               4'd3:    v = 16'd28;
               4'd4:    v = 16'd32;
               4'd5:    v = 16'd36;
               4'd6:    v = 16'd40;
               4'd7:    v = 16'd44;
               4'd8:    v = 16'd48;
               4'd9:    v = 16'd56;
               4'd10:   v = 16'd64;
               default: v = 16'd72;
            endcase
         end else begin
            k = j - 5'd12;
            case (k[1:0])
               2'd0:    v = 16'd5;
               2'd1:    v = 16'd6;
               2'd2:    v = 16'd7;
               default: v = 16'd8;
            endcase
            v = v << (4 + k[4:2]);
         end
      end
      return v[11:0];
   endfunction

endpackage

// File: rtl/sdiv_tick_gen.sv
module sdiv_tick_gen #(
   parameter int unsigned IDX_W   = 6,
   parameter int unsigned RATIO_W = 12,
   parameter int unsigned TICKS   = 4
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [IDX_W-1:0]   idx_i,
   output logic               tick_o,
   output logic [IDX_W-1:0]   cur_idx_o
);
   localparam int unsigned PH_W = $clog2(TICKS);

   logic [IDX_W-1:0]   idx_q;
   logic [PH_W-1:0]    ph_q;
   logic [RATIO_W-1:0] cnt_q;
   logic               tick_q;
   logic [RATIO_W-1:0] r_new;
   logic [RATIO_W-1:0] r_cur;
   logic [PH_W-1:0]    ph_nxt;

   // Length of sub-period p: ratio split into TICKS parts, the
   // remainder spread one clock each over the leading parts.
   function automatic logic [RATIO_W-1:0] part_len(input logic [RATIO_W-1:0] r,
                                                   input logic [PH_W-1:0]    p);
      logic [RATIO_W-1:0] rem;
      rem = r & RATIO_W'(TICKS - 1);
      if (RATIO_W'(p) < rem) return (r >> PH_W) + RATIO_W'(1);
      return r >> PH_W;
   endfunction

   assign r_new  = RATIO_W'(sdiv_pkg::ratio_of(idx_i));
   assign r_cur  = RATIO_W'(sdiv_pkg::ratio_of(idx_q));
   assign ph_nxt = ph_q + PH_W'(1);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         idx_q  <= '0;
         ph_q   <= '0;
         cnt_q  <= part_len(RATIO_W'(sdiv_pkg::ratio_of('0)), '0) - RATIO_W'(1);
         tick_q <= 1'b0;
      end else if (idx_i != idx_q) begin
         idx_q  <= idx_i;
         ph_q   <= '0;
         cnt_q  <= part_len(r_new, '0) - RATIO_W'(1);
         tick_q <= 1'b0;
      end else if (cnt_q == '0) begin
         ph_q   <= ph_nxt;
         cnt_q  <= part_len(r_cur, ph_nxt) - RATIO_W'(1);
         tick_q <= 1'b1;
      end else begin
         cnt_q  <= cnt_q - RATIO_W'(1);
         tick_q <= 1'b0;
      end
   end

   assign tick_o    = tick_q;
   assign cur_idx_o = idx_q;
endmodule

// File: rtl/sdiv_nearest_search.sv
module sdiv_nearest_search #(
   parameter int unsigned IDX_W     = 6,
   parameter int unsigned RATIO_W   = 12,
   parameter int unsigned ERR_W     = 16,
   parameter int unsigned LOW_EXCL  = 22,
   parameter int unsigned HIGH_INCL = 3840
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               start_i,
   input  logic [RATIO_W-1:0] ratio_i,
   output logic               done_o,
   output logic [IDX_W-1:0]   idx_o,
   output logic               err_o,
   output logic               busy_o
);
   logic               busy_q;
   logic [IDX_W-1:0]   pos_q;
   logic [IDX_W-1:0]   best_idx_q;
   logic [ERR_W-1:0]   best_err_q;
   logic [RATIO_W-1:0] want_q;
   logic [RATIO_W-1:0] entry;
   logic [RATIO_W-1:0] diff;
   logic               out_of_range;
   logic               better;

   assign entry        = RATIO_W'(sdiv_pkg::ratio_of(pos_q));
   assign diff         = (entry > want_q) ? (entry - want_q) : (want_q - entry);
   assign better       = ERR_W'(diff) < best_err_q;
   assign out_of_range = (ratio_i <= RATIO_W'(LOW_EXCL)) || (ratio_i > RATIO_W'(HIGH_INCL));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         busy_q     <= 1'b0;
         pos_q      <= '0;
         best_idx_q <= '0;
         best_err_q <= '1;
         want_q     <= '0;
         done_o     <= 1'b0;
         idx_o      <= '0;
         err_o      <= 1'b0;
      end else begin
         done_o <= 1'b0;
         if (!busy_q) begin
            if (start_i) begin
               if (out_of_range) begin
                  done_o <= 1'b1;
                  err_o  <= 1'b1;
                  idx_o  <= '0;
               end else begin
                  busy_q     <= 1'b1;
                  pos_q      <= '0;
                  best_idx_q <= '0;
                  best_err_q <= '1;
                  want_q     <= ratio_i;
               end
            end
         end else if (diff == '0) begin
            busy_q <= 1'b0;
            done_o <= 1'b1;
            err_o  <= 1'b0;
            idx_o  <= pos_q;
         end else if (pos_q == '1) begin
            busy_q <= 1'b0;
            done_o <= 1'b1;
            err_o  <= 1'b0;
            idx_o  <= better ? pos_q : best_idx_q;
         end else begin
            if (better) begin
               best_err_q <= ERR_W'(diff);
               best_idx_q <= pos_q;
            end
            pos_q <= pos_q + IDX_W'(1);
         end
      end
   end

   assign busy_o = busy_q;
endmodule

// File: rtl/sdiv_scl_divider.sv
module sdiv_scl_divider #(
   parameter int unsigned IDX_W         = 6,
   parameter int unsigned RATIO_W       = 12,
   parameter int unsigned ERR_W         = 16,
   parameter int unsigned TICKS_PER_SCL = 4,
   parameter int unsigned RATIO_LOW     = 22,
   parameter int unsigned RATIO_HIGH    = 3840
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [IDX_W-1:0]   div_idx_i,
   output logic               bit_tick_o,
   input  logic               srch_start_i,
   input  logic [RATIO_W-1:0] srch_ratio_i,
   output logic               srch_done_o,
   output logic [IDX_W-1:0]   srch_idx_o,
   output logic               srch_err_o
);
   localparam int unsigned MIN_PART = RATIO_LOW / TICKS_PER_SCL;

   logic               search_busy;
   logic [IDX_W-1:0]   cur_idx;

   generate
      if (IDX_W != 6) begin : g_bad_idx
         $error("IDX_W must be 6: the ratio table has 64 entries");
      end
      if (RATIO_W < 12 || RATIO_HIGH >= (1 << RATIO_W)) begin : g_bad_ratio
         $error("RATIO_W too narrow for the largest ratio");
      end
      if (ERR_W < RATIO_W) begin : g_bad_err
         $error("ERR_W must hold any ratio difference");
      end
      if (TICKS_PER_SCL < 2 || (TICKS_PER_SCL & (TICKS_PER_SCL - 1)) != 0) begin : g_bad_ticks
         $error("TICKS_PER_SCL must be a power of two of at least 2");
      end
      if (MIN_PART < 2) begin : g_bad_part
         $error("Smallest ratio too short for the tick count");
      end
   endgenerate

   sdiv_tick_gen #(
      .IDX_W   (IDX_W),
      .RATIO_W (RATIO_W),
      .TICKS   (TICKS_PER_SCL)
   ) u_tick (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .idx_i     (div_idx_i),
      .tick_o    (bit_tick_o),
      .cur_idx_o (cur_idx)
   );

   sdiv_nearest_search #(
      .IDX_W     (IDX_W),
      .RATIO_W   (RATIO_W),
      .ERR_W     (ERR_W),
      .LOW_EXCL  (RATIO_LOW),
      .HIGH_INCL (RATIO_HIGH)
   ) u_search (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .start_i (srch_start_i),
      .ratio_i (srch_ratio_i),
      .done_o  (srch_done_o),
      .idx_o   (srch_idx_o),
      .err_o   (srch_err_o),
      .busy_o  (search_busy)
   );
endmodule

// File: rtl/sdiv_scl_divider_chk.sv
module sdiv_scl_divider_chk #(
   parameter int unsigned IDX_W      = 6,
   parameter int unsigned RATIO_W    = 12,
   parameter int unsigned RATIO_LOW  = 22,
   parameter int unsigned RATIO_HIGH = 3840
) (
   input logic               clk_i,
   input logic               rst_ni,
   input logic [IDX_W-1:0]   div_idx_i,
   input logic               bit_tick_o,
   input logic               srch_start_i,
   input logic [RATIO_W-1:0] srch_ratio_i,
   input logic               srch_done_o,
   input logic [IDX_W-1:0]   srch_idx_o,
   input logic               srch_err_o,
   input logic               search_busy,
   input logic [IDX_W-1:0]   cur_idx
);
   // R3: no tick right after an index change is seen
   p_reload_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (div_idx_i != cur_idx) |=> !bit_tick_o);

   // R3: ticks are never adjacent
   p_tick_spaced_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bit_tick_o |=> !bit_tick_o);

   // R10: completion is a single-cycle pulse
   p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      srch_done_o |=> !srch_done_o);

   // R9: a rejected request answers on the next cycle with the error flag
   p_invalid_quick_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (srch_start_i && !search_busy &&
       (srch_ratio_i <= RATIO_W'(RATIO_LOW) || srch_ratio_i > RATIO_W'(RATIO_HIGH)))
      |=> (srch_done_o && srch_err_o));

   // R9: the error result carries index 0
   p_err_idx_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (srch_done_o && srch_err_o) |-> (srch_idx_o == '0));

   // R7: a good result only ends a running scan
   p_done_from_scan_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (srch_done_o && !srch_err_o) |-> $past(search_busy));
endmodule

bind sdiv_scl_divider sdiv_scl_divider_chk #(
   .IDX_W      (IDX_W),
   .RATIO_W    (RATIO_W),
   .RATIO_LOW  (RATIO_LOW),
   .RATIO_HIGH (RATIO_HIGH)
) u_chk (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .div_idx_i    (div_idx_i),
   .bit_tick_o   (bit_tick_o),
   .srch_start_i (srch_start_i),
   .srch_ratio_i (srch_ratio_i),
   .srch_done_o  (srch_done_o),
   .srch_idx_o   (srch_idx_o),
   .srch_err_o   (srch_err_o),
   .search_busy  (search_busy),
   .cur_idx      (cur_idx)
);

// File: tb/tb_sdiv_scl_divider.sv
module tb_sdiv_scl_divider;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 190000;

   localparam int TAB [64] = '{
      30, 32, 36, 42, 48, 52, 60, 72, 80, 88, 104, 128, 144, 160, 192, 240,
      288, 320, 384, 480, 576, 640, 768, 960, 1152, 1280, 1536, 1920, 2304, 2560, 3072, 3840,
      22, 24, 26, 28, 32, 36, 40, 44, 48, 56, 64, 72, 80, 96, 112, 128,
      160, 192, 224, 256, 320, 384, 448, 512, 640, 768, 896, 1024, 1280, 1536, 1792, 2048};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [5:0]  div_idx = '0;
   logic        tick;
   logic        start = 1'b0;
   logic [11:0] ratio = '0;
   logic        done;
   logic [5:0]  sidx;
   logic        serr;

   int nchecks = 0;
   int nerr    = 0;
   int cyc     = 0;
   bit ended   = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   sdiv_scl_divider dut (
      .clk_i        (clk),
      .rst_ni       (rst_n),
      .div_idx_i    (div_idx),
      .bit_tick_o   (tick),
      .srch_start_i (start),
      .srch_ratio_i (ratio),
      .srch_done_o  (done),
      .srch_idx_o   (sidx),
      .srch_err_o   (serr)
   );

   task automatic finish_run();
      if (!ended) begin
         ended = 1;
         $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > WATCHDOG) begin
         nchecks++;
         nerr++;
         $display("FAIL watchdog: got %0d cycles expected below %0d", cyc, WATCHDOG);
         finish_run();
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      nchecks++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int part0(input int r);
      return r / 4 + ((r % 4) > 0 ? 1 : 0);
   endfunction

   function automatic void ref_search(input int r, output int idx, output int steps,
                                      output bit err);
      int best;
      int m;
      err = (r <= 22) || (r > 3840);
      idx = 0;
      steps = 0;
      if (err) return;
      best = 65535;
      m = 0;
      for (int i = 0; i < 64; i++) begin
         int d;
         d = TAB[i] - r;
         if (d < 0) d = -d;
         if (d == 0) begin
            idx = i;
            steps = i;
            return;
         end else if (d < best) begin
            best = d;
            m = i;
         end
      end
      idx = m;
      steps = 63;
   endfunction

   // Counts edges from now and records the 1st and 4th tick positions.
   task automatic measure(input int r, input int off, input string req);
      int n;
      int seen;
      int t1;
      int t4;
      n = 0; seen = 0; t1 = -1; t4 = -1;
      while (seen < 4 && n < 2 * r + 40) begin
         @(posedge clk);
         n++;
         @(negedge clk);
         if (tick) begin
            seen++;
            if (seen == 1) t1 = n;
            if (seen == 4) t4 = n;
         end
      end
      chk(t1 == part0(r) + off, req, "first tick edge", t1, part0(r) + off);
      chk(t4 == r + off, req, "fourth tick edge", t4, r + off);
   endtask

   task automatic run_search(input int r, input string req);
      int eidx;
      int esteps;
      bit eerr;
      int elat;
      int n;
      ref_search(r, eidx, esteps, eerr);
      elat = eerr ? 1 : esteps + 2;
      start = 1'b1;
      ratio = 12'(r);
      @(posedge clk);
      n = 1;
      @(negedge clk);
      start = 1'b0;
      while (!done && n < 100) begin
         @(posedge clk);
         n++;
         @(negedge clk);
      end
      chk(n == elat, req, "done latency", n, elat);
      chk(serr == eerr, req, "error flag", int'(serr), int'(eerr));
      chk(int'(sidx) == eidx, req, "result index", int'(sidx), eidx);
      @(posedge clk);
      @(negedge clk);
      chk(!done, "R10", "done one cycle", int'(done), 0);
   endtask

   initial begin
      int n;
      int cur;
      void'($urandom(32'h5eed_1234));
      // R4: reset state
      repeat (3) @(negedge clk);
      chk(!tick, "R4", "tick in reset", int'(tick), 0);
      chk(!done, "R4", "done in reset", int'(done), 0);
      rst_n = 1'b1;
      measure(30, 0, "R4");

      // R1 R2: every index, reached through an index change
      for (int i = 1; i < 64; i++) begin
         div_idx = 6'(i);
         measure(TAB[i], 1, (i < 32) ? "R1" : "R2");
      end
      div_idx = 6'd0;
      measure(TAB[0], 1, "R1");

      // R3: change in the middle of a period restarts the divider
      div_idx = 6'd5;
      repeat (20) @(negedge clk);
      div_idx = 6'd40;
      measure(TAB[40], 1, "R3");

      // R2: random indices
      cur = 40;
      for (int k = 0; k < 8; k++) begin
         int nx;
         nx = int'($urandom_range(63, 0));
         if (nx == cur) nx = (nx + 1) % 64;
         cur = nx;
         div_idx = 6'(nx);
         measure(TAB[nx], 1, "R2");
      end

      // Search, directed corners
      run_search(30, "R7");
      run_search(32, "R7");
      run_search(3840, "R7");
      run_search(23, "R6");
      run_search(25, "R6");
      run_search(2100, "R8");
      run_search(1000, "R5");
      run_search(22, "R9");
      run_search(3841, "R9");
      run_search(0, "R9");
      // R5: random valid requests
      for (int k = 0; k < 30; k++) begin
         run_search(int'($urandom_range(3840, 23)), "R5");
      end

      // R10: start during a scan is ignored
      start = 1'b1;
      ratio = 12'd23;
      @(posedge clk);
      n = 1;
      @(negedge clk);
      start = 1'b0;
      repeat (2) begin
         @(posedge clk);
         n++;
         @(negedge clk);
      end
      start = 1'b1;
      ratio = 12'd30;
      @(posedge clk);
      n++;
      @(negedge clk);
      start = 1'b0;
      while (!done && n < 100) begin
         @(posedge clk);
         n++;
         @(negedge clk);
      end
      chk(n == 65, "R10", "latency with ignored start", n, 65);
      chk(int'(sidx) == 32, "R10", "index with ignored start", int'(sidx), 32);

      finish_run();
   end
endmodule